// File: doc/BRIEF.md
# Single-Beat/Burst Transfer Sequencer

This block sits between a data cache controller and a 64-bit system bus. It takes one access request at a time: an address, a byte count, a read/write flag and a 4-bit storage-attribute field. Together with the global cache-enable and cache-lock inputs, these decide the transfer type. A transfer is either a single data beat of 1 to 8 bytes, which may start at any byte offset, or a four-beat burst that fills a 32-byte cache line.

Once a request is accepted, the sequencer presents the start address, the transfer length and a burst flag. It then puts out the address and byte enables of the current beat and steps to the next beat on each transfer acknowledge. Burst beats start at the double word that holds the requested address and wrap within the line. A single beat that would run past an 8-byte boundary is refused with an error pulse and is never issued. A one-cycle completion pulse follows the last acknowledged beat.

Top module: `xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `err` are low.
- R2: A request whose attribute bit 3 (write-through) or bit 2 (caching-inhibited) is set is issued as one beat with `xfer_burst` low, and a single acknowledge ends it.
- R3: A request is also issued as one beat when `cache_en` is low or `cache_lock` is high, whatever its attribute bits.
- R4: Any other legal request, whether read or write, becomes a burst: `xfer_burst` high, `xfer_bytes` = 32, and `start_addr` equal to the request address with bits [2:0] cleared.
- R5: The four burst beats present the line address with bits [4:3] = (request bits [4:3] + n) mod 4 for beat n = 0..3, bits [2:0] zero, upper bits unchanged, and `beat_be` = 8'hFF.
- R6: For a single beat, `start_addr` and `beat_addr` equal the request address exactly, `xfer_bytes` equals the request size, and `beat_be` = ((1<<size)-1) << addr[2:0], where bit k enables byte lane k.
- R7: A request with size 0, size above 8, or addr[2:0]+size above 8 raises `err` for one cycle on the next cycle and starts no transfer.
- R8: The beat advances only on `ack`; without it the beat address and byte enables hold.
- R9: `done` is high for exactly one cycle, in the cycle after the final beat's acknowledge, and `busy` drops in that same cycle.
- R10: A request presented while `busy` is high is ignored, and an `ack` while idle has no effect.
- R11: `xfer_write` reflects the write flag of the accepted request for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; sampled only while idle |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 4 | Byte count, 1 to 8 |
| req_write | input | 1 | 1 = write, 0 = read or fetch |
| req_attr | input | 4 | Storage attributes; bit 3 write-through, bit 2 caching-inhibited |
| cache_en | input | 1 | Data cache enabled |
| cache_lock | input | 1 | Data cache locked |
| ack | input | 1 | Transfer acknowledge for the current beat |
| busy | output | 1 | Transfer in progress |
| xfer_burst | output | 1 | 1 = four-beat burst, 0 = single beat |
| xfer_write | output | 1 | Direction of the transfer in progress |
| start_addr | output | 32 | Start address of the transfer |
| xfer_bytes | output | 6 | Total transfer length in bytes |
| beat_addr | output | 32 | Address of the current beat |
| beat_be | output | 8 | Byte-lane enables of the current beat |
| done | output | 1 | One-cycle pulse after the last beat |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
The checker watches every cycle for the properties that hold between cycles. These are: burst beats have full byte enables and a double-word-aligned address, the double-word index steps by one on each burst acknowledge, the beat holds while no acknowledge arrives, a single beat ends on its one acknowledge, and `done` and `err` are isolated pulses with the right cause. Only the bench scenarios can show that the transfer type matches each attribute and cache-state combination, that single-beat byte enables fit every size and offset, and that requests crossing a boundary are refused. Those scenarios also check that a request arriving mid-transfer leaves the transfer untouched.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    localparam int ADDR_W     = 32;
    localparam int BUS_BYTES  = 8;
    localparam int OFS_W      = $clog2(BUS_BYTES);
    localparam int LINE_BEATS = 4;
    localparam int IDX_W      = $clog2(LINE_BEATS);
    localparam int LINE_BYTES = BUS_BYTES * LINE_BEATS;
    localparam int LINE_W     = $clog2(LINE_BYTES);
    localparam int SIZE_W     = 4;
    localparam int XB_W       = LINE_W + 1;
    localparam int ATTR_W     = 4;
    localparam int ATTR_WT    = 3;
    localparam int ATTR_CI    = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic              write;
        logic [ATTR_W-1:0] attr;
    } xfer_req_t;

    typedef struct packed {
        logic              burst;
        logic              write;
        logic [ADDR_W-1:0] start;
        logic [SIZE_W-1:0] size;
        logic [IDX_W-1:0]  idx;
    } xfer_ctx_t;

    function automatic logic [BUS_BYTES-1:0] lane_mask(
        input logic [OFS_W-1:0]  ofs,
        input logic [SIZE_W-1:0] size
    );
        logic [2*BUS_BYTES-1:0] m;
        m = ({{(2*BUS_BYTES-1){1'b0}}, 1'b1} << size) - 1'b1;
        m = m << ofs;
        return m[BUS_BYTES-1:0];
    endfunction

    function automatic logic single_fits(
        input logic [OFS_W-1:0]  ofs,
        input logic [SIZE_W-1:0] size
    );
        logic [SIZE_W:0] last_b;
        last_b = {{(SIZE_W+1-OFS_W){1'b0}}, ofs} + {1'b0, size};
        return (size != '0) && (size <= SIZE_W'(BUS_BYTES))
            && (last_b <= (SIZE_W+1)'(BUS_BYTES));
    endfunction

endpackage

// File: rtl/xfer_seq_classify.sv
module xfer_seq_classify
    import xfer_seq_pkg::*;
(
    input  xfer_req_t req,
    input  logic      cache_en,
    input  logic      cache_lock,
    output logic      use_burst,
    output logic      legal
);
    logic attr_single;
    logic mode_single;

    always_comb begin
        attr_single = req.attr[ATTR_WT] | req.attr[ATTR_CI];
        mode_single = ~cache_en | cache_lock;
        use_burst   = ~(attr_single | mode_single);
        legal       = use_burst ? 1'b1 : single_fits(req.addr[OFS_W-1:0], req.size);
    end
endmodule

// File: rtl/xfer_seq_beat_gen.sv
module xfer_seq_beat_gen
    import xfer_seq_pkg::*;
(
    input  xfer_ctx_t             ctx,
    output logic [ADDR_W-1:0]     beat_addr,
    output logic [BUS_BYTES-1:0]  beat_be
);
    logic [IDX_W-1:0] dw_idx;

    always_comb begin
        dw_idx = ctx.start[LINE_W-1:OFS_W] + ctx.idx;
        if (ctx.burst) begin
            beat_addr = {ctx.start[ADDR_W-1:LINE_W], dw_idx, {OFS_W{1'b0}}};
            beat_be   = '1;
        end else begin
            beat_addr = ctx.start;
            beat_be   = lane_mask(ctx.start[OFS_W-1:0], ctx.size);
        end
    end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic                 req_write,
    input  logic [ATTR_W-1:0]    req_attr,
    input  logic                 cache_en,
    input  logic                 cache_lock,
    input  logic                 ack,
    output logic                 busy,
    output logic                 xfer_burst,
    output logic                 xfer_write,
    output logic [ADDR_W-1:0]    start_addr,
    output logic [XB_W-1:0]      xfer_bytes,
    output logic [ADDR_W-1:0]    beat_addr,
    output logic [BUS_BYTES-1:0] beat_be,
    output logic                 done,
    output logic                 err
);
    seq_state_e state_q;
    xfer_ctx_t  ctx_q;
    xfer_req_t  req;
    logic       use_burst;
    logic       legal;
    logic       last_beat;
    logic       done_q;
    logic       err_q;

    assign req = '{addr: req_addr, size: req_size, write: req_write, attr: req_attr};

    xfer_seq_classify u_classify (
        .req        (req),
        .cache_en   (cache_en),
        .cache_lock (cache_lock),
        .use_burst  (use_burst),
        .legal      (legal)
    );

    xfer_seq_beat_gen u_beat (
        .ctx       (ctx_q),
        .beat_addr (beat_addr),
        .beat_be   (beat_be)
    );

    assign last_beat = ctx_q.burst ? (ctx_q.idx == IDX_W'(LINE_BEATS - 1)) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (legal) begin
                            state_q     <= ST_RUN;
                            ctx_q.burst <= use_burst;
                            ctx_q.write <= req.write;
                            ctx_q.start <= use_burst
                                ? {req.addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}}
                                : req.addr;
                            ctx_q.size  <= req.size;
                            ctx_q.idx   <= '0;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (ack) begin
                        if (last_beat) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            ctx_q.idx <= ctx_q.idx + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q == ST_RUN);
    assign xfer_burst = ctx_q.burst;
    assign xfer_write = ctx_q.write;
    assign start_addr = ctx_q.start;
    assign xfer_bytes = ctx_q.burst ? XB_W'(LINE_BYTES) : XB_W'(ctx_q.size);
    assign done       = done_q;
    assign err        = err_q;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk
    import xfer_seq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 ack,
    input logic                 busy,
    input logic                 xfer_burst,
    input logic [ADDR_W-1:0]    beat_addr,
    input logic [BUS_BYTES-1:0] beat_be
    ,input logic                done,
    input logic                 err
);
    assert_burst_lanes_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && xfer_burst) |-> (beat_be == '1 && beat_addr[OFS_W-1:0] == '0));

    assert_burst_step_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && xfer_burst && ack) |=>
            (!busy || beat_addr[LINE_W-1:OFS_W] == $past(beat_addr[LINE_W-1:OFS_W]) + 1'b1));

    assert_hold_no_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack) |=> (busy && $stable(beat_addr) && $stable(beat_be)));

    assert_single_one_ack_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !xfer_burst && ack) |=> (!busy && done));

    assert_done_cause_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy && ack) && !busy));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && $past(req_valid && !busy)));

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
endmodule

bind xfer_seq xfer_seq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .ack        (ack),
    .busy       (busy),
    .xfer_burst (xfer_burst),
    .beat_addr  (beat_addr),
    .beat_be    (beat_be),
    .done       (done),
    .err        (err)
);

// File: tb/xfer_seq_tb_top.sv
module xfer_seq_tb_top;
    import xfer_seq_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic [SIZE_W-1:0]    req_size = '0;
    logic                 req_write = 1'b0;
    logic [ATTR_W-1:0]    req_attr = '0;
    logic                 cache_en = 1'b1;
    logic                 cache_lock = 1'b0;
    logic                 ack = 1'b0;
    logic                 busy, xfer_burst, xfer_write, done, err;
    logic [ADDR_W-1:0]    start_addr, beat_addr;
    logic [XB_W-1:0]      xfer_bytes;
    logic [BUS_BYTES-1:0] beat_be;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xfer_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_attr(req_attr),
        .cache_en(cache_en), .cache_lock(cache_lock), .ack(ack),
        .busy(busy), .xfer_burst(xfer_burst), .xfer_write(xfer_write),
        .start_addr(start_addr), .xfer_bytes(xfer_bytes), .beat_addr(beat_addr),
        .beat_be(beat_be), .done(done), .err(err)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_lanes(input int ofs, input int size);
        int m;
        m = ((1 << size) - 1) << ofs;
        return m[7:0];
    endfunction

    // Runs one request through; expected burst decision and legality computed here.
    task automatic run_req(input logic [31:0] a, input int size, input logic wr,
                           input logic [3:0] attr, input logic en, input logic lk,
                           input bit stall, input bit intrude, input string tag);
        bit exp_burst, exp_ok;
        int beats;
        exp_burst = !attr[3] && !attr[2] && en && !lk;
        exp_ok = exp_burst || (size >= 1 && size <= 8 && (a[2:0] + size) <= 8);
        req_addr = a; req_size = size[3:0]; req_write = wr; req_attr = attr;
        cache_en = en; cache_lock = lk; req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        if (!exp_ok) begin
            check("R7", {tag, " err"}, err, 1);
            check("R7", {tag, " busy"}, busy, 0);
            step();
            check("R7", {tag, " err pulse"}, err, 0);
            return;
        end
        check("R2", {tag, " busy"}, busy, 1);
        check(exp_burst ? "R4" : "R3", {tag, " burst"}, xfer_burst, exp_burst);
        check("R11", {tag, " write"}, xfer_write, wr);
        if (exp_burst) begin
            check("R4", {tag, " start"}, start_addr, {a[31:3], 3'b000});
            check("R4", {tag, " bytes"}, xfer_bytes, 32);
        end else begin
            check("R6", {tag, " start"}, start_addr, a);
            check("R6", {tag, " bytes"}, xfer_bytes, size);
        end
        beats = exp_burst ? 4 : 1;
        for (int n = 0; n < beats; n++) begin
            logic [1:0] dw;
            dw = a[4:3] + n[1:0];
            if (exp_burst) begin
                check("R5", {tag, " beat addr"}, beat_addr, {a[31:5], dw, 3'b000});
                check("R5", {tag, " beat be"}, beat_be, 8'hFF);
            end else begin
                check("R6", {tag, " beat addr"}, beat_addr, a);
                check("R6", {tag, " beat be"}, beat_be, exp_lanes(a[2:0], size));
            end
            if (stall) begin
                step();
                check("R8", {tag, " held addr"}, beat_addr,
                      exp_burst ? {a[31:5], dw, 3'b000} : a);
                check("R8", {tag, " still busy"}, busy, 1);
            end
            if (intrude && n == 0) begin
                req_addr = ~a; req_size = 4'd1; req_attr = 4'b0100; req_valid = 1'b1;
                step();
                req_valid = 1'b0;
                check("R10", {tag, " start kept"}, start_addr,
                      exp_burst ? {a[31:3], 3'b000} : a);
                check("R10", {tag, " burst kept"}, xfer_burst, exp_burst);
            end
            check("R9", {tag, " no early done"}, done, 0);
            ack = 1'b1;
            step();
            ack = 1'b0;
        end
        check("R9", {tag, " done"}, done, 1);
        check("R9", {tag, " idle"}, busy, 0);
        step();
        check("R9", {tag, " done pulse"}, done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "reset busy", busy, 0);
        check("R1", "reset done", done, 0);
        check("R1", "reset err", err, 0);

        // R10: ack while idle
        ack = 1'b1; step(); ack = 1'b0;
        check("R10", "idle ack busy", busy, 0);
        check("R10", "idle ack done", done, 0);

        // Attribute and cache-state sweep (R2, R3, R4)
        for (int at = 0; at < 16; at++)
            for (int m = 0; m < 8; m++)
                run_req(32'h1000_0000 + (at << 8) + (m << 3) + m, 4, m[2], at[3:0],
                        m[0], m[1], 0, 0, "cls");

        // Single-beat size/offset sweep (R6, R7)
        for (int s = 0; s <= 9; s++)
            for (int o = 0; o < 8; o++)
                run_req(32'h2000_0040 + o, s, o[0], 4'b0100, 1, 0, 0, 0, "single");

        // Burst critical double word wrap (R5), with stalls (R8) and intrusion (R10)
        for (int d = 0; d < 4; d++)
            for (int o = 0; o < 8; o += 3)
                run_req(32'h3000_0AE0 + (d << 3) + o, 8, d[0], 4'b0010, 1, 0,
                        1, d == 2, "burst");

        run_req(32'h4000_0013, 2, 1, 4'b1000, 1, 0, 1, 1, "single_wt");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule